// File: doc/BRIEF.md
# 8-bit Arithmetic and Logic Unit with Full Flag Generation

This block is the arithmetic and logic unit of an 8-bit accumulator-style processor core. Each cycle it can accept one operation. Two-operand operations combine an accumulator operand with a second operand. Single-operand operations act on the accumulator alone. The block returns an 8-bit result, a strobe that tells the register file whether to write that result, and a complete new flag byte.

The flag byte includes the two undocumented copy bits (bits 5 and 3 of the flag byte). It also includes the exact half-carry, subtract and carry side effects of negate, complement, set-carry and complement-carry.

The operation is captured on a clock edge while `opValid` is high. Its outputs appear on the registers of that same edge, so the latency is one cycle. Operand fetch, the register file and decimal adjust belong to the surrounding core.

Top module: `alu8_flags`

## Requirements
- R1: Flag byte layout is bit7 S (sign), bit6 Z (zero), bit5 copy bit Y, bit4 H (half carry), bit3 copy bit X, bit2 P/V, bit1 N (subtract), bit0 C (carry).
- R2: With `opUnary`=0, `opSel` picks the operation: 000 add, 001 add-with-carry, 010 subtract, 011 subtract-with-carry, 111 compare.
  - The result is the 8-bit value of A+B(+C) or A-B(-C).
  - C is the unsigned carry or borrow out of bit 7, and H is the carry or borrow between bit 3 and bit 4.
  - V (bit 2) flags signed overflow.
  - N is 0 for add and 1 for subtract.
  - Subtract-with-carry of A from itself gives 0xFF with carry set and 0x00 otherwise, and leaves C as it was.
- R3: Logic operations are selected with `opUnary`=0: 100 AND, 101 XOR, 110 OR.
  - N and C are cleared, and P/V is 1 when the result has an even number of one bits.
  - H is 1 for AND and 0 for XOR and OR.
- R4: Compare (`opUnary`=0, `opSel`=111) produces flags identical to subtract. `resWrite` is 0, and `result` carries the difference.
- R5: Increment (`opUnary`=1, 000) and decrement (001) act on A with a second operand of 1.
  - They set S, Z, Y, H, X and V as add or subtract would.
  - N is 0 for increment and 1 for decrement, and C is copied from `flagsIn`.
- R6: Negate (`opUnary`=1, 010) computes 0-A with subtract flags, so C is 1 exactly when A was non-zero.
- R7: Complement (`opUnary`=1, 011) writes the bitwise inverse of A.
  - It sets H and N and copies Y and X from the result.
  - S, Z, P/V and C are taken from `flagsIn`.
- R8: Set-carry (`opUnary`=1, 100) sets C and clears H and N. Complement-carry (101) inverts C, loads H with the old C and clears N.
  - Both copy Y and X from A and keep S, Z and P/V.
  - Both give `resWrite`=0 and `result`=A.
- R9: For arithmetic and logic operations, Y and X are bits 5 and 3 of the 8-bit result. S is bit 7 of the result, and Z is set when the result is zero.
- R10: Unary codes 110 and 111 are reserved: `resWrite`=0, `result`=A, and `flagsOut` equals `flagsIn`.
- R11: Outputs register on the edge where `opValid` is high, and `resValid` is high in exactly the following cycle.
  - Without `opValid` the result, write strobe and flags hold.
  - Reset (`rstN` low) clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation present this cycle |
| opUnary | input | 1 | 0 selects two-operand group, 1 single-operand group |
| opSel | input | 3 | Operation code within the group |
| opA | input | 8 | Accumulator operand |
| opB | input | 8 | Second operand |
| flagsIn | input | 8 | Current flag byte |
| resValid | output | 1 | Registered outputs belong to the previous cycle's operation |
| result | output | 8 | Operation result |
| resWrite | output | 1 | Result should be written to the accumulator |
| flagsOut | output | 8 | New flag byte |

## Verification
A wrong decode strobe or a wrong carry-in polarity inside the block shows up one cycle later on `flagsOut` and `result`. Such an error usually affects a whole class of operand values rather than a single value. The sweep covers every operand A against sixteen spread values of B, with both carry inputs. This makes a half-carry, overflow or borrow error visible within a few hundred operations of the faulty operation. A fault in a kept flag (C on increment, S/Z/P/V on complement) shows as soon as `flagsIn` differs from what the datapath would compute. For that reason `flagsIn` is varied with every operand.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DATA_W = 8;
  localparam int SEL_W  = 3;

  // flag byte bit positions
  localparam int F_S = 7;
  localparam int F_Z = 6;
  localparam int F_Y = 5;
  localparam int F_H = 4;
  localparam int F_X = 3;
  localparam int F_P = 2;
  localparam int F_N = 1;
  localparam int F_C = 0;

  typedef enum logic [2:0] {
    K_ARITH, K_AND, K_XOR, K_OR, K_CPL, K_SCF, K_CCF, K_HOLD
  } kind_e;

  typedef struct packed {
    kind_e kind;
    logic  sub;       // subtract instead of add
    logic  useCarry;  // include incoming carry
    logic  xZero;     // left operand forced to zero, right operand is A
    logic  yOne;      // right operand forced to one
    logic  keepC;     // carry copied from incoming flags
    logic  wr;        // result is written back
  } strobe_t;
endpackage

// File: rtl/alu8_ctrl.sv
module alu8_ctrl
  import alu8_pkg::*;
(
  input  logic             opUnary,
  input  logic [SEL_W-1:0] opSel,
  output strobe_t          strobe
);
  always_comb begin
    strobe = '{kind: K_ARITH, sub: 1'b0, useCarry: 1'b0, xZero: 1'b0,
               yOne: 1'b0, keepC: 1'b0, wr: 1'b1};
    if (!opUnary) begin
      unique case (opSel)
        3'b100: strobe.kind = K_AND;
        3'b101: strobe.kind = K_XOR;
        3'b110: strobe.kind = K_OR;
        3'b111: begin
          strobe.sub = 1'b1;
          strobe.wr  = 1'b0;
        end
        default: begin
          strobe.sub      = opSel[1];
          strobe.useCarry = opSel[0];
        end
      endcase
    end else begin
      unique case (opSel)
        3'b000: begin
          strobe.yOne  = 1'b1;
          strobe.keepC = 1'b1;
        end
        3'b001: begin
          strobe.yOne  = 1'b1;
          strobe.keepC = 1'b1;
          strobe.sub   = 1'b1;
        end
        3'b010: begin
          strobe.xZero = 1'b1;
          strobe.sub   = 1'b1;
        end
        3'b011: strobe.kind = K_CPL;
        3'b100: begin
          strobe.kind = K_SCF;
          strobe.wr   = 1'b0;
        end
        3'b101: begin
          strobe.kind = K_CCF;
          strobe.wr   = 1'b0;
        end
        default: begin
          strobe.kind = K_HOLD;
          strobe.wr   = 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/alu8_dp.sv
module alu8_dp
  import alu8_pkg::*;
(
  input  strobe_t           strobe,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] flagsIn,
  output logic [DATA_W-1:0] resNext,
  output logic [DATA_W-1:0] flagsNext
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] xOp, yOp, yEff, arithRes, logicRes;
  logic [DATA_W:0]   sumFull;
  logic [HALF_W:0]   sumHalf;
  logic              carryUse, cin, carryOut, halfOut, ovf;

  always_comb begin
    xOp      = strobe.xZero ? '0 : opA;
    yOp      = strobe.yOne ? DATA_W'(1) : (strobe.xZero ? opA : opB);
    carryUse = strobe.useCarry & flagsIn[F_C];
    // subtraction: x + ~y + 1 - c
    yEff     = strobe.sub ? ~yOp : yOp;
    cin      = strobe.sub ? ~carryUse : carryUse;
    sumFull  = {1'b0, xOp} + {1'b0, yEff} + {{DATA_W{1'b0}}, cin};
    sumHalf  = {1'b0, xOp[HALF_W-1:0]} + {1'b0, yEff[HALF_W-1:0]}
             + {{HALF_W{1'b0}}, cin};
    arithRes = sumFull[DATA_W-1:0];
    carryOut = strobe.sub ? ~sumFull[DATA_W] : sumFull[DATA_W];
    halfOut  = strobe.sub ? ~sumHalf[HALF_W] : sumHalf[HALF_W];
    ovf      = (xOp[DATA_W-1] == yEff[DATA_W-1]) &&
               (arithRes[DATA_W-1] != xOp[DATA_W-1]);
  end

  always_comb begin
    unique case (strobe.kind)
      K_AND:   logicRes = opA & opB;
      K_XOR:   logicRes = opA ^ opB;
      default: logicRes = opA | opB;
    endcase
  end

  always_comb begin
    resNext   = opA;
    flagsNext = flagsIn;
    unique case (strobe.kind)
      K_ARITH: begin
        resNext        = arithRes;
        flagsNext[F_S] = arithRes[DATA_W-1];
        flagsNext[F_Z] = (arithRes == '0);
        flagsNext[F_Y] = arithRes[5];
        flagsNext[F_H] = halfOut;
        flagsNext[F_X] = arithRes[3];
        flagsNext[F_P] = ovf;
        flagsNext[F_N] = strobe.sub;
        flagsNext[F_C] = strobe.keepC ? flagsIn[F_C] : carryOut;
      end
      K_AND, K_XOR, K_OR: begin
        resNext        = logicRes;
        flagsNext[F_S] = logicRes[DATA_W-1];
        flagsNext[F_Z] = (logicRes == '0);
        flagsNext[F_Y] = logicRes[5];
        flagsNext[F_H] = (strobe.kind == K_AND);
        flagsNext[F_X] = logicRes[3];
        flagsNext[F_P] = ~^logicRes;
        flagsNext[F_N] = 1'b0;
        flagsNext[F_C] = 1'b0;
      end
      K_CPL: begin
        resNext        = ~opA;
        flagsNext[F_Y] = ~opA[5];
        flagsNext[F_X] = ~opA[3];
        flagsNext[F_H] = 1'b1;
        flagsNext[F_N] = 1'b1;
      end
      K_SCF: begin
        flagsNext[F_Y] = opA[5];
        flagsNext[F_X] = opA[3];
        flagsNext[F_H] = 1'b0;
        flagsNext[F_N] = 1'b0;
        flagsNext[F_C] = 1'b1;
      end
      K_CCF: begin
        flagsNext[F_Y] = opA[5];
        flagsNext[F_X] = opA[3];
        flagsNext[F_H] = flagsIn[F_C];
        flagsNext[F_N] = 1'b0;
        flagsNext[F_C] = ~flagsIn[F_C];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic              opUnary,
  input  logic [SEL_W-1:0]  opSel,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] flagsIn,
  output logic              resValid,
  output logic [DATA_W-1:0] result,
  output logic              resWrite,
  output logic [DATA_W-1:0] flagsOut
);
  strobe_t           strobe;
  logic [DATA_W-1:0] resNext, flagsNext;

  alu8_ctrl u_ctrl (.opUnary(opUnary), .opSel(opSel), .strobe(strobe));

  alu8_dp u_dp (
    .strobe(strobe), .opA(opA), .opB(opB), .flagsIn(flagsIn),
    .resNext(resNext), .flagsNext(flagsNext)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0;
      result   <= '0;
      resWrite <= 1'b0;
      flagsOut <= '0;
    end else begin
      resValid <= opValid;
      if (opValid) begin
        result   <= resNext;
        resWrite <= strobe.wr;
        flagsOut <= flagsNext;
      end
    end
  end

  // R11: output strobe trails the input strobe by one cycle
  a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> resValid);
  a_r11_idle_follows: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> !resValid && $stable(flagsOut) && $stable(result));

  // R4: compare never writes and reports a subtraction
  a_r4_compare_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !opUnary && opSel == 3'b111) |=> !resWrite && flagsOut[F_N]);

  // R3: logic group clears N and C
  a_r3_logic_clears_nc: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !opUnary && opSel[2] && opSel != 3'b111)
      |=> flagsOut[F_N:F_C] == 2'b00);

  // R5: increment and decrement keep carry
  a_r5_incdec_keep_carry: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opUnary && opSel[2:1] == 2'b00)
      |=> flagsOut[F_C] == $past(flagsIn[F_C]));

  // R6: negate carry reflects a non-zero operand
  a_r6_neg_carry: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opUnary && opSel == 3'b010)
      |=> flagsOut[F_C] == ($past(opA) != '0));

  // R8: set-carry outcome
  a_r8_scf_flags: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opUnary && opSel == 3'b100)
      |=> flagsOut[F_C] && !flagsOut[F_H] && !flagsOut[F_N] && !resWrite);

  // R10: reserved codes pass flags through
  a_r10_reserved_hold: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opUnary && opSel[2:1] == 2'b11)
      |=> flagsOut == $past(flagsIn) && !resWrite);
endmodule

// File: tb/alu8_flags_test.sv
`timescale 1ns/1ps
module alu8_flags_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic       opUnary = 1'b0;
  logic [2:0] opSel = 3'b000;
  logic [7:0] opA = 8'h00, opB = 8'h00, flagsIn = 8'h00;
  logic       resValid, resWrite;
  logic [7:0] result, flagsOut;

  int compared = 0;
  int mismatched = 0;

  always #4 clk = ~clk;  // 125 MHz

  alu8_flags uut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opUnary(opUnary),
    .opSel(opSel), .opA(opA), .opB(opB), .flagsIn(flagsIn),
    .resValid(resValid), .result(result), .resWrite(resWrite),
    .flagsOut(flagsOut)
  );

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit par(input int v);
    int cnt = 0;
    for (int i = 0; i < 8; i++) cnt += (v >> i) & 1;
    return (cnt % 2) == 0;
  endfunction

  // arithmetic reference: returns {result, flags}
  function automatic logic [15:0] arith(input int a, input int b, input int c,
                                        input bit sub, input bit keepC,
                                        input int fin);
    int r, h, sr, sa, sb;
    logic [7:0] f, res;
    sa = (a > 127) ? a - 256 : a;
    sb = (b > 127) ? b - 256 : b;
    if (sub) begin
      r = a - b - c; h = (a % 16) - (b % 16) - c; sr = sa - sb - c;
    end else begin
      r = a + b + c; h = (a % 16) + (b % 16) + c; sr = sa + sb + c;
    end
    res  = r[7:0];
    f[7] = res[7];
    f[6] = (res == 0);
    f[5] = res[5];
    f[4] = sub ? (h < 0) : (h > 15);
    f[3] = res[3];
    f[2] = (sr < -128) || (sr > 127);
    f[1] = sub;
    f[0] = keepC ? fin[0] : (sub ? (r < 0) : (r > 255));
    return {res, f};
  endfunction

  // full reference: {write, result, flags}
  function automatic logic [16:0] model(input bit un, input int sel,
                                        input int a, input int b,
                                        input int fin);
    logic [15:0] rf;
    logic [7:0] f, res;
    int c;
    c = fin & 1;
    f = fin[7:0];
    if (!un) begin
      case (sel)
        0: return {1'b1, arith(a, b, 0, 0, 0, fin)};
        1: return {1'b1, arith(a, b, c, 0, 0, fin)};
        2: return {1'b1, arith(a, b, 0, 1, 0, fin)};
        3: return {1'b1, arith(a, b, c, 1, 0, fin)};
        7: return {1'b0, arith(a, b, 0, 1, 0, fin)};
        default: begin
          res = (sel == 4) ? 8'(a & b) : (sel == 5) ? 8'(a ^ b) : 8'(a | b);
          f = {res[7], res == 0, res[5], sel == 4, res[3], par(res), 2'b00};
          return {1'b1, res, f};
        end
      endcase
    end
    case (sel)
      0: return {1'b1, arith(a, 1, 0, 0, 1, fin)};
      1: return {1'b1, arith(a, 1, 0, 1, 1, fin)};
      2: return {1'b1, arith(0, a, 0, 1, 0, fin)};
      3: begin
        res = ~a[7:0];
        f[5] = res[5]; f[3] = res[3]; f[4] = 1; f[1] = 1;
        return {1'b1, res, f};
      end
      4: begin
        f[5] = a[5]; f[3] = a[3]; f[4] = 0; f[1] = 0; f[0] = 1;
        return {1'b0, a[7:0], f};
      end
      5: begin
        f[5] = a[5]; f[3] = a[3]; f[4] = c[0]; f[1] = 0; f[0] = ~c[0];
        return {1'b0, a[7:0], f};
      end
      default: return {1'b0, a[7:0], f};
    endcase
  endfunction

  function automatic string reqOf(input bit un, input int sel);
    if (!un) return (sel == 7) ? "R4" : (sel >= 4) ? "R3" : "R2";
    case (sel)
      0, 1: return "R5";
      2: return "R6";
      3: return "R7";
      4, 5: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic runOp(input bit un, input int sel, input int a, input int b,
                       input int fin);
    logic [16:0] e;
    string t;
    @(negedge clk);
    opValid = 1'b1; opUnary = un; opSel = 3'(sel);
    opA = 8'(a); opB = 8'(b); flagsIn = 8'(fin);
    @(posedge clk); #1;
    opValid = 1'b0;
    e = model(un, sel, a, b, fin);
    t = reqOf(un, sel);
    chk({t, " R11 valid"}, resValid, 1);
    chk({t, " write"}, resWrite, e[16]);
    chk({t, " result"}, result, e[15:8]);
    chk({t, " R1 R9 flags"}, flagsOut, e[7:0]);
  endtask

  initial begin
    #2000000;
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R11 reset valid", resValid, 0);
    chk("R11 reset result", result, 0);
    chk("R11 reset write", resWrite, 0);
    chk("R11 reset flags", flagsOut, 0);
    @(negedge clk) rstN = 1'b1;

    // two-operand group: all A against spread B, both carry inputs
    for (int sel = 0; sel < 8; sel++)
      for (int a = 0; a < 256; a++)
        for (int k = 0; k < 16; k++)
          for (int c = 0; c < 2; c++)
            runOp(0, sel, a, k * 17, ((a ^ 8'h5A ^ k) & 8'hFE) | c);

    // R2: subtract-with-carry of A from itself
    for (int a = 0; a < 256; a += 5)
      for (int c = 0; c < 2; c++) begin
        runOp(0, 3, a, a, c);
        chk("R2 sbc self value", result, c ? 8'hFF : 8'h00);
        chk("R2 sbc self carry", flagsOut[0], c);
      end

    // single-operand group, every code including reserved ones
    for (int sel = 0; sel < 8; sel++)
      for (int a = 0; a < 256; a++)
        for (int c = 0; c < 2; c++)
          runOp(1, sel, a, 8'hA5 ^ a, ((a * 37 + 11) & 8'hFE) | c);

    // R6 boundary: negate of zero clears carry, of 0x80 overflows
    runOp(1, 2, 0, 0, 8'hFF);
    chk("R6 neg zero carry", flagsOut[0], 0);
    runOp(1, 2, 8'h80, 0, 0);
    chk("R6 neg 80 overflow", flagsOut[2], 1);

    // R11: outputs hold while idle
    runOp(0, 0, 8'h12, 8'h34, 0);
    @(negedge clk); opA = 8'hFF; opB = 8'hFF; opSel = 3'b011;
    @(posedge clk); #1;
    chk("R11 idle valid", resValid, 0);
    chk("R11 idle hold result", result, 8'h46);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule